// File: doc/BRIEF.md
# Read Completion Generator

This block turns one decoded read request into the completion-with-data stream that answers it. A request carries a dword address into local memory, a dword length, first and last byte enables, a tag and a requester ID, plus a flag marking it as a single-dword IO read. The block works out how many bytes the request really covers. It cuts the reply into completions that respect the configured maximum payload size. When a request has to be split, the first completion is trimmed so that every following one starts on a 128-byte boundary.

For each completion a header is offered on a valid/ready channel. It carries the dword length, the remaining byte count, the low seven address bits, the completer ID, the tag, the requester ID and the status. The header is followed by one data beat per dword on a second valid/ready channel. Each beat drives a dword read address into a local memory with a combinational read port and returns the word with disabled byte lanes forced to zero. Only one request is in flight at a time.

Top module: `rd_cpl_gen`

## Requirements
- R1: While reset is asserted and right after it, `hdr_valid_o` and `dat_valid_o` are low and `req_ready_o` is high.
- R2: For a memory read, the first completion's byte count is the request's byte span. For a one-dword request with first enable 0 it is 1; otherwise it runs from the lowest set bit of the first enable to the highest set bit. For a longer request it is length*4 minus the index of the lowest set first-enable bit, minus (3 minus the index of the highest set last-enable bit).
- R3: Every completion's byte count equals the request's byte span minus the bytes delivered by its earlier completions.
- R4: Maximum payload setting n (0..5) allows 32<<n dwords; settings 6 and 7 act as 5. If the dwords still owed exceed that limit, the completion length is the limit minus bits [6:2] of its start byte address. Otherwise it is the full remainder.
- R5: The first completion starts at byte address 4*dword address plus the index of the lowest set first-enable bit. Each following one starts where the previous ended: previous start + 4*length − (previous start mod 4). The lower address field is start mod 128.
- R6: The completer ID is {bus number, 8'h00}, with the bus number taken when the request is accepted. Tag and requester ID are copied from the request, and status is 3'b000.
- R7: An IO read gives exactly one completion: length 1, byte count 4, lower address 0, one data beat. The request length input is ignored.
- R8: Completion data beats read dword address (request dword address + dword index within the request) modulo the memory size. There is one beat per dword of the completion, and `dat_last_o` is set on the last beat only.
- R9: In a data beat, byte lane i is bits [8i+7:8i]. It is zero unless enabled: by the first enable for dword index 0, by the last enable for the final dword of a longer request, and always for middle dwords.
- R10: Each completion's header precedes its beats, completions leave in address order, and `req_ready_o` stays low from acceptance until the final beat's handshake.
- R11: A header or beat held without ready keeps its valid high and its fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_io_i | input | 1 | Request is a single-dword IO read |
| req_dw_addr_i | input | MEM_AW | Dword address of the request in local memory |
| req_len_i | input | LEN_W | Dword length (1 and up) |
| req_fbe_i | input | 4 | First dword byte enables |
| req_lbe_i | input | 4 | Last dword byte enables |
| req_tag_i | input | TAG_W | Request tag |
| req_rid_i | input | RID_W | Requester ID |
| mps_i | input | 3 | Maximum payload setting |
| bus_i | input | 8 | Captured bus number |
| hdr_valid_o | output | 1 | Completion header valid |
| hdr_ready_i | input | 1 | Completion header taken |
| hdr_len_o | output | LEN_W | Completion length in dwords |
| hdr_bc_o | output | LEN_W+2 | Remaining byte count |
| hdr_lo_addr_o | output | 7 | Lower address field |
| hdr_cid_o | output | 16 | Completer ID |
| hdr_tag_o | output | TAG_W | Tag |
| hdr_rid_o | output | RID_W | Requester ID |
| hdr_status_o | output | 3 | Completion status |
| mem_addr_o | output | MEM_AW | Dword read address |
| mem_rdata_i | input | 32 | Read data, same cycle |
| dat_valid_o | output | 1 | Data beat valid |
| dat_ready_i | input | 1 | Data beat taken |
| dat_o | output | 32 | Masked data dword |
| dat_last_o | output | 1 | Last beat of this completion |

## Verification
The assertions assume a memory request has a length of at least one and no more than the length field holds. They also assume the last byte enable is nonzero whenever the length exceeds one, and that the memory answers in the same cycle. Under those conditions a completion always has a nonzero length that fits the payload limit, and the remaining byte count always covers its data. The bench builds enables as contiguous runs for multi-dword requests and uses every enable value only for one-dword and IO reads. It sweeps lengths, 128-byte offsets and payload settings, including the clamped ones. Throughout, it drives pseudo-random ready patterns and scrambles the bus and payload inputs after each request is accepted.

// File: rtl/rcg_pkg.sv
`timescale 1ns/1ps
package rcg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DAT} rcg_st_e;

  localparam logic [2:0] CPL_OK  = 3'b000;
  localparam logic [2:0] MPS_TOP = 3'd5;

  function automatic logic [1:0] be_lo(input logic [3:0] be);
    if (be[0])      return 2'd0;
    else if (be[1]) return 2'd1;
    else if (be[2]) return 2'd2;
    else if (be[3]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [1:0] be_hi(input logic [3:0] be);
    if (be[3])      return 2'd3;
    else if (be[2]) return 2'd2;
    else if (be[1]) return 2'd1;
    return 2'd0;
  endfunction
endpackage

// File: rtl/rcg_span.sv
`timescale 1ns/1ps
module rcg_span
  import rcg_pkg::*;
#(
  parameter int LEN_W = 10,
  localparam int BC_W = LEN_W + 2
) (
  input  logic             io_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [3:0]       fbe_i,
  input  logic [3:0]       lbe_i,
  input  logic [4:0]       dw_lo_i,
  output logic [BC_W-1:0]  bc_o,
  output logic [6:0]       lo_o
);
  logic [1:0] f_lo, f_hi, l_hi;

  always_comb begin
    f_lo = be_lo(fbe_i);
    f_hi = be_hi(fbe_i);
    l_hi = be_hi(lbe_i);
    if (io_i) begin
      lo_o = '0;
      bc_o = BC_W'(4);
    end else begin
      lo_o = {dw_lo_i, f_lo};
      if (len_i == LEN_W'(1)) begin
        if (fbe_i == 4'h0) bc_o = BC_W'(1);
        else               bc_o = BC_W'(f_hi) - BC_W'(f_lo) + BC_W'(1);
      end else begin
        bc_o = {len_i, 2'b00} - BC_W'(f_lo) - BC_W'(2'd3 - l_hi);
      end
    end
  end
endmodule

// File: rtl/rcg_chunk.sv
`timescale 1ns/1ps
module rcg_chunk
  import rcg_pkg::*;
#(
  parameter int LEN_W = 10,
  localparam int MW = (LEN_W + 1 > 11) ? LEN_W + 1 : 11
) (
  input  logic [LEN_W-1:0] rem_i,
  input  logic [6:0]       lo_i,
  input  logic [2:0]       mps_i,
  output logic [LEN_W-1:0] chunk_o
);
  logic [2:0]    mps_eff;
  logic [MW-1:0] cap;

  always_comb begin
    mps_eff = (mps_i > MPS_TOP) ? MPS_TOP : mps_i;
    cap     = MW'(32) << mps_eff;
    // trim the oversized piece so the next one starts on a 128-byte line
    if (MW'(rem_i) > cap) chunk_o = LEN_W'(cap - MW'(lo_i[6:2]));
    else                  chunk_o = rem_i;
  end
endmodule

// File: rtl/rcg_lane.sv
`timescale 1ns/1ps
module rcg_lane #(
  parameter int LEN_W = 10
) (
  input  logic [LEN_W-1:0] idx_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [3:0]       fbe_i,
  input  logic [3:0]       lbe_i,
  input  logic [31:0]      rdata_i,
  output logic [31:0]      data_o
);
  logic [3:0] mask;

  always_comb begin
    if (idx_i == '0)                        mask = fbe_i;
    else if (idx_i == len_i - LEN_W'(1))    mask = lbe_i;
    else                                    mask = 4'hF;
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign data_o[8*g +: 8] = mask[g] ? rdata_i[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/rd_cpl_gen.sv
`timescale 1ns/1ps
module rd_cpl_gen
  import rcg_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int LEN_W  = 10,
  parameter int TAG_W  = 8,
  parameter int RID_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_io_i,
  input  logic [MEM_AW-1:0]  req_dw_addr_i,
  input  logic [LEN_W-1:0]   req_len_i,
  input  logic [3:0]         req_fbe_i,
  input  logic [3:0]         req_lbe_i,
  input  logic [TAG_W-1:0]   req_tag_i,
  input  logic [RID_W-1:0]   req_rid_i,
  input  logic [2:0]         mps_i,
  input  logic [7:0]         bus_i,
  output logic               hdr_valid_o,
  input  logic               hdr_ready_i,
  output logic [LEN_W-1:0]   hdr_len_o,
  output logic [LEN_W+1:0]   hdr_bc_o,
  output logic [6:0]         hdr_lo_addr_o,
  output logic [15:0]        hdr_cid_o,
  output logic [TAG_W-1:0]   hdr_tag_o,
  output logic [RID_W-1:0]   hdr_rid_o,
  output logic [2:0]         hdr_status_o,
  output logic [MEM_AW-1:0]  mem_addr_o,
  input  logic [31:0]        mem_rdata_i,
  output logic               dat_valid_o,
  input  logic               dat_ready_i,
  output logic [31:0]        dat_o,
  output logic               dat_last_o
);
  localparam int BC_W = LEN_W + 2;

  rcg_st_e             st_q;
  logic                io_q;
  logic [LEN_W-1:0]    len_q, idx_q, left_q;
  logic [3:0]          fbe_q, lbe_q;
  logic [MEM_AW-1:0]   base_q;
  logic [TAG_W-1:0]    tag_q;
  logic [RID_W-1:0]    rid_q;
  logic [2:0]          mps_q;
  logic [7:0]          bus_q;
  logic [6:0]          lo_q;
  logic [BC_W-1:0]     bc_q;

  logic [BC_W-1:0]     span_bc;
  logic [6:0]          span_lo;
  logic [LEN_W-1:0]    chunk;
  logic [BC_W-1:0]     adv;

  rcg_span #(.LEN_W(LEN_W)) u_span (
    .io_i   (req_io_i),
    .len_i  (req_len_i),
    .fbe_i  (req_fbe_i),
    .lbe_i  (req_lbe_i),
    .dw_lo_i(req_dw_addr_i[4:0]),
    .bc_o   (span_bc),
    .lo_o   (span_lo)
  );

  rcg_chunk #(.LEN_W(LEN_W)) u_chunk (
    .rem_i  (len_q - idx_q),
    .lo_i   (lo_q),
    .mps_i  (mps_q),
    .chunk_o(chunk)
  );

  rcg_lane #(.LEN_W(LEN_W)) u_lane (
    .idx_i  (idx_q),
    .len_i  (len_q),
    .fbe_i  (fbe_q),
    .lbe_i  (lbe_q),
    .rdata_i(mem_rdata_i),
    .data_o (dat_o)
  );

  assign adv = {chunk, 2'b00} - BC_W'(lo_q[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      io_q   <= 1'b0;
      len_q  <= '0;
      idx_q  <= '0;
      left_q <= '0;
      fbe_q  <= '0;
      lbe_q  <= '0;
      base_q <= '0;
      tag_q  <= '0;
      rid_q  <= '0;
      mps_q  <= '0;
      bus_q  <= '0;
      lo_q   <= '0;
      bc_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          io_q   <= req_io_i;
          len_q  <= req_io_i ? LEN_W'(1) : req_len_i;
          idx_q  <= '0;
          fbe_q  <= req_fbe_i;
          lbe_q  <= req_lbe_i;
          base_q <= req_dw_addr_i;
          tag_q  <= req_tag_i;
          rid_q  <= req_rid_i;
          mps_q  <= mps_i;
          bus_q  <= bus_i;
          lo_q   <= span_lo;
          bc_q   <= span_bc;
          st_q   <= ST_HDR;
        end
        ST_HDR: if (hdr_ready_i) begin
          left_q <= chunk;
          lo_q   <= lo_q + adv[6:0];
          bc_q   <= bc_q - adv;
          st_q   <= ST_DAT;
        end
        ST_DAT: if (dat_ready_i) begin
          idx_q  <= idx_q + LEN_W'(1);
          left_q <= left_q - LEN_W'(1);
          if (left_q == LEN_W'(1))
            st_q <= (idx_q + LEN_W'(1) == len_q) ? ST_IDLE : ST_HDR;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (st_q == ST_IDLE);
  assign hdr_valid_o   = (st_q == ST_HDR);
  assign dat_valid_o   = (st_q == ST_DAT);
  assign hdr_len_o     = chunk;
  assign hdr_bc_o      = bc_q;
  assign hdr_lo_addr_o = lo_q;
  assign hdr_cid_o     = {bus_q, 8'h00};
  assign hdr_tag_o     = tag_q;
  assign hdr_rid_o     = rid_q;
  assign hdr_status_o  = CPL_OK;
  assign mem_addr_o    = base_q + MEM_AW'(idx_q);
  assign dat_last_o    = (left_q == LEN_W'(1));

  // R10: header and data channels never overlap, and nothing is offered while idle
  a_r10_one_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o || dat_valid_o) |-> !(hdr_valid_o && dat_valid_o) && !req_ready_o);

  a_r11_hdr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o && !hdr_ready_i |=> hdr_valid_o && $stable(hdr_len_o)
      && $stable(hdr_bc_o) && $stable(hdr_lo_addr_o));

  a_r11_dat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_valid_o && !dat_ready_i |=> dat_valid_o && $stable(mem_addr_o) && $stable(dat_last_o));

  a_r4_len_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> hdr_len_o != '0
      && int'(hdr_len_o) <= (32 << ((mps_q > MPS_TOP) ? int'(MPS_TOP) : int'(mps_q))));

  a_r3_bc_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> int'(hdr_bc_o) + 3 + int'(hdr_lo_addr_o[1:0]) >= 4 * int'(hdr_len_o));

  a_r7_io_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o && io_q |-> hdr_len_o == LEN_W'(1) && hdr_bc_o == BC_W'(4) && hdr_lo_addr_o == 7'd0);

  a_r8_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_valid_o && dat_ready_i && dat_last_o |=> !dat_valid_o);
endmodule

// File: tb/sim_rd_cpl_gen.sv
`timescale 1ns/1ps
module sim_rd_cpl_gen;
  localparam int MEM_AW = 10;
  localparam int LEN_W  = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_io = 1'b0;
  logic [MEM_AW-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [3:0] req_fbe = '0, req_lbe = '0;
  logic [7:0] req_tag = '0;
  logic [15:0] req_rid = '0;
  logic [2:0] mps = '0;
  logic [7:0] bus = '0;
  logic hdr_valid, hdr_ready = 1'b0;
  logic [LEN_W-1:0] hdr_len;
  logic [LEN_W+1:0] hdr_bc;
  logic [6:0] hdr_lo;
  logic [15:0] hdr_cid, hdr_rid;
  logic [7:0] hdr_tag;
  logic [2:0] hdr_st;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0] mem_rdata, dat;
  logic dat_valid, dat_ready = 1'b0, dat_last;

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'hC3A50F1E;
  endfunction

  assign mem_rdata = pat(int'(mem_addr));

  rd_cpl_gen #(.MEM_AW(MEM_AW), .LEN_W(LEN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_io_i(req_io),
    .req_dw_addr_i(req_addr), .req_len_i(req_len), .req_fbe_i(req_fbe),
    .req_lbe_i(req_lbe), .req_tag_i(req_tag), .req_rid_i(req_rid),
    .mps_i(mps), .bus_i(bus),
    .hdr_valid_o(hdr_valid), .hdr_ready_i(hdr_ready), .hdr_len_o(hdr_len),
    .hdr_bc_o(hdr_bc), .hdr_lo_addr_o(hdr_lo), .hdr_cid_o(hdr_cid),
    .hdr_tag_o(hdr_tag), .hdr_rid_o(hdr_rid), .hdr_status_o(hdr_st),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .dat_valid_o(dat_valid), .dat_ready_i(dat_ready), .dat_o(dat), .dat_last_o(dat_last)
  );

  int n_vec = 0, n_err = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit st_h = 0, st_d = 0;
  int p_len, p_bc, p_lo, p_addr;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int blo(input logic [3:0] b);
    for (int i = 0; i < 4; i++) if (b[i]) return i;
    return 0;
  endfunction

  function automatic int bhi(input logic [3:0] b);
    for (int i = 3; i >= 0; i--) if (b[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] lanes(input logic [3:0] m);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = {8{m[i]}};
    return r;
  endfunction

  // waits for a handshake on the header (want_dat=0) or data channel
  task automatic wait_hs(input bit want_dat, output bit ok);
    ok = 0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      req_valid = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hdr_ready = lfsr[0] | lfsr[5];
      dat_ready = lfsr[2] | lfsr[9];
      bus = lfsr[7:0] ^ 8'h5A;
      mps = lfsr[11:9];
      #1;
      if (st_h) chk(hdr_valid && int'(hdr_len) == p_len && int'(hdr_bc) == p_bc
                    && int'(hdr_lo) == p_lo, "R11 header held", hdr_bc, p_bc);
      if (st_d) chk(dat_valid && int'(mem_addr) == p_addr, "R11 beat held", mem_addr, p_addr);
      st_h = hdr_valid && !hdr_ready;
      st_d = dat_valid && !dat_ready;
      p_len = int'(hdr_len); p_bc = int'(hdr_bc); p_lo = int'(hdr_lo); p_addr = int'(mem_addr);
      if (req_ready) chk(0, "R10 ready while busy", 1, 0);
      if (want_dat ? (dat_valid && dat_ready) : (hdr_valid && hdr_ready)) begin
        ok = 1;
        return;
      end
    end
    chk(0, want_dat ? "R10 beat timeout" : "R10 header timeout", 0, 1);
  endtask

  task automatic run_req(input bit io, input int addr, input int len, input logic [3:0] fbe,
                         input logic [3:0] lbe, input int tag, input int rid, input int m_set,
                         input int bus_v);
    int elen, bc, a, m, n, cap, c, idx;
    bit ok;
    logic [3:0] msk;
    @(negedge clk);
    req_io = io; req_addr = MEM_AW'(addr); req_len = LEN_W'(len);
    req_fbe = fbe; req_lbe = lbe; req_tag = 8'(tag); req_rid = 16'(rid);
    mps = 3'(m_set); bus = 8'(bus_v); req_valid = 1'b1;
    #1;
    chk(req_ready, "R10 idle accepts", req_ready, 1);
    @(posedge clk);
    st_h = 0; st_d = 0;
    // expectation
    elen = io ? 1 : len;
    if (io) begin bc = 4; a = 0; end
    else begin
      a = addr * 4 + blo(fbe);
      if (len == 1) bc = (fbe == 4'h0) ? 1 : bhi(fbe) - blo(fbe) + 1;
      else bc = len * 4 - blo(fbe) - (3 - bhi(lbe));
    end
    cap = 32 << ((m_set > 5) ? 5 : m_set);
    m = 0; n = 0;
    while (m < elen) begin
      c = elen - m;
      if (!io && c > cap) c = cap - ((a & 'h7C) >> 2);
      wait_hs(0, ok);
      if (!ok) return;
      chk(int'(hdr_len) == c, io ? "R7 io length" : "R4 completion length", hdr_len, c);
      chk(int'(hdr_bc) == bc - n, m == 0 ? "R2 first byte count" : "R3 remaining byte count",
          hdr_bc, bc - n);
      chk(int'(hdr_lo) == (io ? 0 : (a & 'h7F)), io ? "R7 io lower address" : "R5 lower address",
          hdr_lo, a & 'h7F);
      chk(hdr_cid == {8'(bus_v), 8'h00}, "R6 completer id", hdr_cid, {8'(bus_v), 8'h00});
      chk(int'(hdr_tag) == (tag & 'hFF) && int'(hdr_rid) == (rid & 'hFFFF),
          "R6 tag and requester id", {hdr_tag, hdr_rid}, {8'(tag), 16'(rid)});
      chk(hdr_st == 3'b000, "R6 status", hdr_st, 0);
      for (int i = 0; i < c; i++) begin
        idx = m + i;
        wait_hs(1, ok);
        if (!ok) return;
        if (idx == 0) msk = fbe;
        else if (idx == elen - 1) msk = lbe;
        else msk = 4'hF;
        chk(int'(mem_addr) == ((addr + idx) % (1 << MEM_AW)), "R8 read address",
            mem_addr, (addr + idx) % (1 << MEM_AW));
        chk(dat == (pat((addr + idx) % (1 << MEM_AW)) & lanes(msk)), "R9 masked data",
            dat, pat((addr + idx) % (1 << MEM_AW)) & lanes(msk));
        chk(dat_last == (i == c - 1), "R8 last flag", dat_last, i == c - 1);
      end
      m += c;
      n += c * 4 - (a & 3);
      a += c * 4 - (a & 3);
    end
    @(negedge clk);
    #1;
    chk(req_ready && !hdr_valid && !dat_valid, "R10 idle after last beat", req_ready, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    int ofs;
    repeat (2) @(negedge clk);
    #1;
    chk(!hdr_valid && !dat_valid && req_ready, "R1 in reset", {hdr_valid, dat_valid, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!hdr_valid && !dat_valid && req_ready, "R1 after reset", {hdr_valid, dat_valid, req_ready}, 1);

    // sweep of length, 128-byte offset and payload size
    for (int len = 1; len <= 70; len++)
      for (int oi = 0; oi < 5; oi++)
        for (int ms = 0; ms < 2; ms++) begin
          case (oi)
            0: ofs = 0;  1: ofs = 5;  2: ofs = 17;  3: ofs = 31;  default: ofs = 30;
          endcase
          run_req(0, ((len % 32) << 5) | ofs, len, 4'(4'hF << ((len + oi) % 4)),
                  4'hF >> ((len * 3 + oi) % 4), len + oi, 16'h1000 + len, ms, len * 7 + oi);
        end
    // one-dword reads with every enable pattern (R2 span rule)
    for (int b = 0; b < 16; b++) run_req(0, 3 + b, 1, 4'(b), 4'hF, b, b * 3, b % 6, b);
    // long reads, including clamped payload settings (R4)
    run_req(0, 13, 1023, 4'hE, 4'h7, 1, 2, 0, 3);
    run_req(0, 13, 1023, 4'hF, 4'hF, 4, 5, 3, 6);
    run_req(0, 0, 1023, 4'h8, 4'h1, 7, 8, 5, 9);
    run_req(0, 1000, 600, 4'hC, 4'h3, 10, 11, 7, 12);
    run_req(0, 29, 300, 4'hF, 4'hF, 13, 14, 6, 15);
    // IO reads: request length ignored (R7)
    for (int b = 0; b < 16; b++) run_req(1, b * 37, (b * 11) % 100 + 1, 4'(b), 4'h0, b + 100, b, b % 8, b + 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule